// File: doc/BRIEF.md
# Serial Transceiver Lane Power-Up Sequencer

This block takes a four-lane serial transceiver out of power-down and reset in a fixed, timed order. A single-cycle start request makes it raise every lane power-down bit, every lane reset bit and both PLL reset bits at once. It holds that state for one wait interval, then drops the bits in six groups and holds for one full interval after each group. Lanes are handled in pairs, and each pair has its own PLL. Within a pair, power-down is cleared first, then the PLL reset, then the two lane resets. The second pair starts only after the first pair is fully out of reset.

The wait interval is fixed at build time as a duration in nanoseconds together with the clock frequency. Board-specific configuration bits travel beside the control bits unchanged, so the transceiver sees one coherent control word. A busy flag covers the whole sequence, and a one-cycle done pulse marks its end.

Top module: `lane_pwrup_seq`

## Requirements
- R1: While reset is asserted, and in the first idle cycle after it, every power-down, lane reset and PLL reset output is 0, and busy and done are 0. Reset is asynchronous and clears the outputs at once, even in the middle of a sequence.
- R2: A start request sampled while busy and done are both low sets busy high on the next cycle. In that same cycle all four power-down bits, all four lane reset bits and both PLL reset bits go to 1.
- R3: The all-asserted state and each state after a release last exactly WAIT cycles, where WAIT = CLK_MHZ*WAIT_NS/1000 and is at least 1.
- R4: For lane pair 0 (lanes 0 and 1, PLL bit 0), the releases come in this order. First both power-down bits 0 and 1, then PLL reset bit 0, then both lane reset bits 0 and 1. Each group is one release step.
- R5: Lane pair 1 (lanes 2 and 3, PLL bit 1) releases in the same order as pair 0. Its first release comes only after the lane resets of pair 0 have been cleared.
- R6: While busy, no control bit ever goes from 0 back to 1.
- R7: Done is high for exactly one cycle, 7*WAIT cycles after the first busy cycle. In that cycle busy is 0 and all control bits are 0, and busy stays low afterwards.
- R8: A start request is ignored while busy is high and also in the done cycle. The running sequence keeps its timing, and no new sequence begins.
- R9: The configuration output always equals the configuration input, whatever the state of the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled on the clock edge |
| board_cfg_i | input | CFG_W (8) | Static board configuration bits |
| pdn_o | output | 2*PAIRS (4) | Lane power-down, bit i = lane i, 1 = powered down |
| lane_rst_o | output | 2*PAIRS (4) | Lane reset, bit i = lane i, 1 = in reset |
| pll_rst_o | output | PAIRS (2) | PLL reset, bit k = PLL of lanes 2k and 2k+1, 1 = in reset |
| cfg_o | output | CFG_W (8) | Configuration bits passed through to the transceiver |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the sequence completes |

## Verification
The assertions check on every cycle the properties that relate the outputs at one moment. These are the release order within each pair, the handoff from pair 0 to pair 1, the bits never rising during a sequence, and the bits of a pair moving together. They also check that done is a single-cycle pulse with all bits cleared, and that a counter in the checker measures each hold as exactly WAIT cycles. Some behaviour can only be shown by the bench scenarios: the exact cycle of done relative to the start pulse, the sequence going on unchanged after a start request mid-sequence or in the done cycle, the configuration pass-through while the input changes, and reset cutting a sequence short.

// File: rtl/lane_pwrup_pkg.sv
`timescale 1ns/1ps
package lane_pwrup_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;

  // Release steps per lane pair: power-down, PLL reset, lane reset
  localparam int unsigned STEPS_PER_PAIR = 3;

  function automatic int unsigned wait_cycles(input int unsigned mhz,
                                              input int unsigned ns);
    int unsigned c;
    c = (mhz * ns) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/lane_pwrup_timer.sv
`timescale 1ns/1ps
module lane_pwrup_timer #(
  parameter int unsigned WAIT_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign tick_o = run_i && (cnt_q == CW'(WAIT_CYC - 1));

  always_comb begin
    cnt_en = run_i || (cnt_q != '0);
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lane_pwrup_fsm.sv
`timescale 1ns/1ps
module lane_pwrup_fsm
  import lane_pwrup_pkg::*;
#(
  parameter int unsigned LAST_PHASE = 6,
  parameter int unsigned PW         = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          tick_i,
  output logic          run_o,
  output logic          done_o,
  output logic [PW-1:0] phase_o
);
  seq_state_e    state_q, state_d;
  logic [PW-1:0] phase_q, phase_d;
  logic          upd_en;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    upd_en  = (state_q != ST_IDLE) || start_i;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_RUN;
          phase_d = '0;
        end
      end
      ST_RUN: begin
        if (tick_i) begin
          if (phase_q == PW'(LAST_PHASE)) state_d = ST_FIN;
          else                            phase_d = phase_q + PW'(1);
        end
      end
      ST_FIN: begin
        state_d = ST_IDLE;
        phase_d = '0;
      end
      default: begin
        state_d = ST_IDLE;
        phase_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      phase_q <= phase_d;
    end
  end

  assign run_o   = (state_q == ST_RUN);
  assign done_o  = (state_q == ST_FIN);
  assign phase_o = phase_q;
endmodule

// File: rtl/lane_pwrup_word.sv
`timescale 1ns/1ps
module lane_pwrup_word
  import lane_pwrup_pkg::*;
#(
  parameter int unsigned PAIRS = 2,
  parameter int unsigned PW    = 3
) (
  input  logic                 run_i,
  input  logic [PW-1:0]        phase_i,
  output logic [2*PAIRS-1:0]   pdn_o,
  output logic [2*PAIRS-1:0]   lane_rst_o,
  output logic [PAIRS-1:0]     pll_rst_o
);
  // A bit stays asserted while the phase index is below its release step.
  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    localparam int unsigned STEP_PDN  = STEPS_PER_PAIR * k + 1;
    localparam int unsigned STEP_PLL  = STEPS_PER_PAIR * k + 2;
    localparam int unsigned STEP_LRST = STEPS_PER_PAIR * k + 3;

    logic hold_pdn, hold_pll, hold_lrst;

    assign hold_pdn  = run_i && (phase_i < PW'(STEP_PDN));
    assign hold_pll  = run_i && (phase_i < PW'(STEP_PLL));
    assign hold_lrst = run_i && (phase_i < PW'(STEP_LRST));

    assign pdn_o[2*k+1:2*k]      = {2{hold_pdn}};
    assign lane_rst_o[2*k+1:2*k] = {2{hold_lrst}};
    assign pll_rst_o[k]          = hold_pll;
  end
endmodule

// File: rtl/lane_pwrup_seq.sv
`timescale 1ns/1ps
module lane_pwrup_seq
  import lane_pwrup_pkg::*;
#(
  parameter int unsigned PAIRS   = 2,
  parameter int unsigned CFG_W   = 8,
  parameter int unsigned CLK_MHZ = 125,
  parameter int unsigned WAIT_NS = 15000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [CFG_W-1:0]   board_cfg_i,
  output logic [2*PAIRS-1:0] pdn_o,
  output logic [2*PAIRS-1:0] lane_rst_o,
  output logic [PAIRS-1:0]   pll_rst_o,
  output logic [CFG_W-1:0]   cfg_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int unsigned WAIT_CYC   = wait_cycles(CLK_MHZ, WAIT_NS);
  localparam int unsigned LAST_PHASE = STEPS_PER_PAIR * PAIRS;
  localparam int unsigned PW         = $clog2(LAST_PHASE + 1);

  logic          run, tick;
  logic [PW-1:0] phase;

  lane_pwrup_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .tick_o (tick)
  );

  lane_pwrup_fsm #(.LAST_PHASE(LAST_PHASE), .PW(PW)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .tick_i  (tick),
    .run_o   (run),
    .done_o  (done_o),
    .phase_o (phase)
  );

  lane_pwrup_word #(.PAIRS(PAIRS), .PW(PW)) u_word (
    .run_i      (run),
    .phase_i    (phase),
    .pdn_o      (pdn_o),
    .lane_rst_o (lane_rst_o),
    .pll_rst_o  (pll_rst_o)
  );

  assign busy_o = run;
  assign cfg_o  = board_cfg_i;
endmodule

// File: rtl/lane_pwrup_chk.sv
`timescale 1ns/1ps
module lane_pwrup_chk
  import lane_pwrup_pkg::*;
#(
  parameter int unsigned PAIRS   = 2,
  parameter int unsigned CLK_MHZ = 125,
  parameter int unsigned WAIT_NS = 15000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic [2*PAIRS-1:0] pdn_o,
  input logic [2*PAIRS-1:0] lane_rst_o,
  input logic [PAIRS-1:0]   pll_rst_o,
  input logic               busy_o,
  input logic               done_o
);
  localparam int unsigned WAIT_CYC = wait_cycles(CLK_MHZ, WAIT_NS);
  localparam int unsigned NB       = 5 * PAIRS;
  localparam int unsigned LW       = $clog2(WAIT_CYC + 1) + 1;

  logic [NB-1:0] ctrl, ctrl_q;
  logic          busy_q;
  logic [LW-1:0] len_q;

  assign ctrl = {pdn_o, lane_rst_o, pll_rst_o};

  // Length of the current stable stretch while busy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      busy_q <= 1'b0;
      len_q  <= '0;
    end else begin
      ctrl_q <= ctrl;
      busy_q <= busy_o;
      if (!busy_o || (ctrl != ctrl_q)) len_q <= '0;
      else                             len_q <= len_q + LW'(1);
    end
  end

  a_r2_launch_all_set: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !done_o) |=> (busy_o && (&ctrl)));

  a_r3_hold_length: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && busy_q && (ctrl != ctrl_q)) |-> (len_q == LW'(WAIT_CYC - 1)));

  a_r6_no_reassert: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ((ctrl & ~$past(ctrl)) == '0));

  a_r7_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && (ctrl == '0) && $past(busy_o)));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && done_o) |=> !busy_o);

  a_r1_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o) |-> (ctrl == '0));

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair_chk
    a_r4_pair_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
      (pdn_o[2*k] == pdn_o[2*k+1]) && (lane_rst_o[2*k] == lane_rst_o[2*k+1]));

    a_r4_pll_after_pdn: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !pll_rst_o[k]) |-> (pdn_o[2*k+1:2*k] == 2'b00));

    a_r4_lrst_after_pll: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !lane_rst_o[2*k]) |-> !pll_rst_o[k]);

    if (k > 0) begin : g_handoff
      a_r5_pair_handoff: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !pdn_o[2*k]) |-> (lane_rst_o[2*k-1:2*k-2] == 2'b00));
    end
  end
endmodule

bind lane_pwrup_seq lane_pwrup_chk #(
  .PAIRS   (PAIRS),
  .CLK_MHZ (CLK_MHZ),
  .WAIT_NS (WAIT_NS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .pdn_o      (pdn_o),
  .lane_rst_o (lane_rst_o),
  .pll_rst_o  (pll_rst_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/lane_pwrup_seq_tb.sv
`timescale 1ns/1ps
module lane_pwrup_seq_tb;
  localparam int PAIRS   = 2;
  localparam int CFG_W   = 8;
  localparam int CLK_MHZ = 125;
  localparam int WAIT_NS = 64;
  localparam int W       = 8;          // 125 * 64 / 1000
  localparam int NB      = 5 * PAIRS;
  localparam int SEQ_LEN = 7 * W;

  logic               clk;
  logic               rst_n;
  logic               start;
  logic [CFG_W-1:0]   cfg_in;
  logic [2*PAIRS-1:0] pdn, lrst;
  logic [PAIRS-1:0]   pll;
  logic [CFG_W-1:0]   cfg_out;
  logic               busy, done;

  int checks = 0;
  int errors = 0;

  lane_pwrup_seq #(
    .PAIRS(PAIRS), .CFG_W(CFG_W), .CLK_MHZ(CLK_MHZ), .WAIT_NS(WAIT_NS)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .board_cfg_i (cfg_in),
    .pdn_o       (pdn),
    .lane_rst_o  (lrst),
    .pll_rst_o   (pll),
    .cfg_o       (cfg_out),
    .busy_o      (busy),
    .done_o      (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [NB-1:0] ctrl_now();
    return {pdn, lrst, pll};
  endfunction

  // Expected word for phase p (number of release steps done)
  function automatic logic [NB-1:0] exp_word(input int p);
    logic [2*PAIRS-1:0] e_pdn, e_lrst;
    logic [PAIRS-1:0]   e_pll;
    for (int k = 0; k < PAIRS; k++) begin
      e_pdn[2*k]    = (p < 3*k + 1);
      e_pdn[2*k+1]  = (p < 3*k + 1);
      e_pll[k]      = (p < 3*k + 2);
      e_lrst[2*k]   = (p < 3*k + 3);
      e_lrst[2*k+1] = (p < 3*k + 3);
    end
    return {e_pdn, e_lrst, e_pll};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(ctrl_now() === '0, req, "ctrl idle", 32'(ctrl_now()), 0);
    chk(busy === 1'b0, req, "busy idle", 32'(busy), 0);
    chk(done === 1'b0, req, "done idle", 32'(done), 0);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; start = 1'b0; cfg_in = 8'hA5;
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1");
    chk(cfg_out === 8'hA5, "R9", "cfg pass", 32'(cfg_out), 32'hA5);
  endtask

  // Runs one sequence; optional extra start pulse in cycle pulse_n
  task automatic t_sequence(input int pulse_n, input bit walk_cfg);
    logic [NB-1:0] prev, expw;
    string req;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    prev = '0;
    for (int n = 0; n <= SEQ_LEN; n++) begin
      if (n < SEQ_LEN) begin
        expw = exp_word(n / W);
        if (n == 0)                   req = "R2";
        else if (n % W != 0)          req = "R3";
        else if (n / W <= 3)          req = "R4";
        else                          req = "R5";
        if (pulse_n >= 0 && n > pulse_n) req = "R8";
        chk(ctrl_now() === expw, req, "ctrl word", 32'(ctrl_now()), 32'(expw));
        chk(busy === 1'b1, req, "busy", 32'(busy), 1);
        chk(done === 1'b0, "R7", "done early", 32'(done), 0);
        if (n > 0)
          chk((ctrl_now() & ~prev) === '0, "R6", "bit rose", 32'(ctrl_now()), 32'(prev));
      end else begin
        chk(done === 1'b1, "R7", "done pulse", 32'(done), 1);
        chk(busy === 1'b0, "R7", "busy at done", 32'(busy), 0);
        chk(ctrl_now() === '0, "R7", "ctrl at done", 32'(ctrl_now()), 0);
      end
      chk(cfg_out === cfg_in, "R9", "cfg pass", 32'(cfg_out), 32'(cfg_in));
      prev = ctrl_now();
      start = (n == pulse_n);
      if (walk_cfg) cfg_in = CFG_W'((n * 37) ^ 8'h5A);
      @(negedge clk);
    end
    start = 1'b0;
    chk_idle(pulse_n == SEQ_LEN ? "R8" : "R7");
    @(negedge clk);
    chk_idle(pulse_n == SEQ_LEN ? "R8" : "R7");
  endtask

  task automatic t_reset_midway();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2 * W + 3) @(negedge clk);
    chk(busy === 1'b1, "R1", "busy before abort", 32'(busy), 1);
    #1 rst_n = 1'b0;
    #1;
    chk_idle("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1");
  endtask

  initial begin
    t_reset_state();
    t_sequence(-1, 1'b0);
    t_sequence(3 * W + 2, 1'b1);
    t_sequence(SEQ_LEN, 1'b1);
    t_sequence(0, 1'b0);
    t_reset_midway();
    t_sequence(-1, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule